// File: doc/BRIEF.md
# Block-Counted Byte-to-Word Transfer Engine

This block moves data between a 16-bit word FIFO and a byte-wide card data port. Data read from the card is packed into FIFO words with the low byte first. Data written to the card is taken from FIFO words, low byte first. Two programmable registers control the size of a transfer: a block length in bytes and a number of blocks. Live countdowns of both values are visible on output ports at all times. A block may have an odd length. In that case the last word of each block carries only one byte.

A transfer starts when a data-transfer launch is issued, which also sets the direction. The launch empties the FIFO. Bytes then move one per accepted handshake. At most one byte is exchanged per clock, and only in a cycle where the request and the acknowledge are both high. When the card supplies data, the engine pauses while the FIFO holds more words than the almost-full level. When data goes to the card, the engine pauses while the FIFO is empty. After the last byte of the last block, the engine drops busy and sets a sticky done flag.

Top module: `blk_byte_xfer`

## Requirements
- R1: After reset the byte and block countdowns both read 1, busy and done are 0, the FIFO count is 0, and neither card request is high.
- R2: Writing the block length (cfg_sel = 0) stores cfg_wdata + 1 and reloads the byte countdown with that value. cfg_wdata is 11 bits wide, so lengths run from 1 to 2048.
- R3: Writing the block count (cfg_sel = 1) stores cfg_wdata + 1. It reloads the block countdown with that value and reloads the byte countdown from the stored block length.
- R4: A launch empties the FIFO, latches the direction (launch_dir = 1 means card to FIFO, 0 means FIFO to card) and raises busy. The FIFO count reads 0 in the following cycle.
- R5: Card to FIFO: the first byte of a pair fills bits 7:0 of a word. The next byte fills bits 15:8 only if the block has bytes left. Otherwise the word is pushed with bits 15:8 equal to zero.
- R6: FIFO to card: bits 7:0 of the head word are sent first. Bits 15:8 are sent next only if the block has bytes left. The head word is then removed.
- R7: Card to FIFO: card_rd_req stays low at a word boundary while the FIFO count exceeds af_level. It resumes once the count falls back to af_level or below.
- R8: FIFO to card: card_wr_req is low whenever the FIFO is empty.
- R9: Each byte moved decrements the byte countdown. When the byte countdown would reach zero, the block countdown decrements and the byte countdown reloads from the block length. Both countdowns are never zero.
- R10: After the last byte of the last block, the block countdown is reloaded, busy falls, and done is set. done stays set until done_clr is asserted.
- R11: A byte moves only in a cycle with request and acknowledge both high, at most one per clock, and the two card requests are never high together.
- R12: While busy, a host push is ignored when the direction is card to FIFO, and a host pop is ignored when the direction is FIFO to card.

Cycle timing of the port:
- card_rd_byte is taken at the clock edge where card_rd_req and card_rd_ack are both high.
- card_wr_byte is valid whenever card_wr_req is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects block length, 1 selects block count |
| cfg_wdata | input | LEN_BITS | Encoded value (stored value is this plus one) |
| af_level | input | AW | Almost-full level for card-to-FIFO transfers |
| launch | input | 1 | Start a data transfer |
| launch_dir | input | 1 | 1: card to FIFO, 0: FIFO to card |
| done_clr | input | 1 | Clears the done flag |
| host_wr_en | input | 1 | Host word push |
| host_wdata | input | 16 | Host word to push |
| host_rd_en | input | 1 | Host word pop |
| host_rdata | output | 16 | FIFO head word |
| fifo_count | output | AW+1 | Words held in the FIFO |
| card_rd_req | output | 1 | Engine ready to take a card byte |
| card_rd_ack | input | 1 | Card presents a byte |
| card_rd_byte | input | 8 | Byte from the card |
| card_wr_req | output | 1 | Engine presents a byte for the card |
| card_wr_ack | input | 1 | Card takes the byte |
| card_wr_byte | output | 8 | Byte for the card |
| blen_left | output | LEN_BITS+1 | Live byte countdown |
| nblk_left | output | LEN_BITS+1 | Live block countdown |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky transfer-complete flag |

## Verification
Some properties are checked by assertions on every cycle:
- the card requests are never high together;
- no byte is offered to the card from an empty FIFO;
- both countdowns stay nonzero;
- a write-side byte decrements the byte countdown by exactly one;
- a launch leaves the FIFO empty;
- the end of a transfer always sets done.

Other behaviours can only be shown by the bench scenarios, because they depend on data or history:
- the byte order inside packed and split words, including the zero high half for odd block lengths;
- the pause at the almost-full level and the resumption after a pop;
- the reload values after register writes in the middle of a transfer;
- the ignored host accesses.

// File: rtl/bx_pkg.sv
package bx_pkg;

    typedef enum logic {
        DIR_TO_CARD   = 1'b0,
        DIR_FROM_CARD = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        SEL_BLOCK_LEN = 1'b0,
        SEL_BLOCK_CNT = 1'b1
    } cfg_sel_e;

    // Engine sequencing state: half = low byte already handled for this word
    typedef struct packed {
        logic      active;
        xfer_dir_e dir;
        logic      half;
        logic [7:0] lo;
        logic      done;
    } eng_state_t;

endpackage

// File: rtl/bx_word_fifo.sv
module bx_word_fifo #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [AW:0]   count
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (st_q.cnt != (AW+1)'(DEPTH)) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = st_q.rp + 1'b1;
            st_d.cnt = st_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= push_data;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;

endmodule

// File: rtl/bx_countdown.sv
module bx_countdown
    import bx_pkg::*;
#(
    parameter int LEN_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  cfg_sel_e            cfg_sel,
    input  logic [LEN_BITS-1:0] cfg_data,
    input  logic                step,
    output logic [LEN_BITS:0]   blen_left,
    output logic [LEN_BITS:0]   nblk_left,
    output logic                last_byte,
    output logic                last_block
);
    localparam int CW = LEN_BITS + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] blen_cfg;
        logic [CW-1:0] nblk_cfg;
        logic [CW-1:0] blen_cnt;
        logic [CW-1:0] nblk_cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CW-1:0] enc;

    always_comb begin
        enc  = {1'b0, cfg_data} + ONE;
        st_d = st_q;
        if (step) begin
            if (st_q.blen_cnt == ONE) begin
                st_d.blen_cnt = st_q.blen_cfg;
                if (st_q.nblk_cnt == ONE) st_d.nblk_cnt = st_q.nblk_cfg;
                else                      st_d.nblk_cnt = st_q.nblk_cnt - ONE;
            end else begin
                st_d.blen_cnt = st_q.blen_cnt - ONE;
            end
        end
        if (cfg_wr) begin
            if (cfg_sel == SEL_BLOCK_LEN) begin
                st_d.blen_cfg = enc;
                st_d.blen_cnt = enc;
            end else begin
                st_d.nblk_cfg = enc;
                st_d.nblk_cnt = enc;
                st_d.blen_cnt = st_q.blen_cfg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{blen_cfg: ONE, nblk_cfg: ONE, blen_cnt: ONE, nblk_cnt: ONE};
        else        st_q <= st_d;
    end

    assign blen_left  = st_q.blen_cnt;
    assign nblk_left  = st_q.nblk_cnt;
    assign last_byte  = (st_q.blen_cnt == ONE);
    assign last_block = (st_q.nblk_cnt == ONE);

endmodule

// File: rtl/bx_engine.sv
module bx_engine
    import bx_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  xfer_dir_e     launch_dir,
    input  logic          done_clr,
    input  logic [AW-1:0] af_level,
    input  logic [AW:0]   fifo_count,
    input  logic [15:0]   fifo_head,
    input  logic          last_byte,
    input  logic          last_block,
    output logic          card_rd_req,
    input  logic          card_rd_ack,
    input  logic [7:0]    card_rd_byte,
    output logic          card_wr_req,
    input  logic          card_wr_ack,
    output logic [7:0]    card_wr_byte,
    output logic          byte_step,
    output logic          eng_push,
    output logic [15:0]   eng_push_data,
    output logic          eng_pop,
    output logic          busy,
    output xfer_dir_e     cur_dir,
    output logic          done
);
    eng_state_t st_d, st_q;
    logic rd_fire, wr_fire;

    always_comb begin
        card_rd_req  = st_q.active && (st_q.dir == DIR_FROM_CARD) &&
                       (st_q.half || (fifo_count <= {1'b0, af_level}));
        card_wr_req  = st_q.active && (st_q.dir == DIR_TO_CARD) && (fifo_count != '0);
        card_wr_byte = st_q.half ? fifo_head[15:8] : fifo_head[7:0];
        rd_fire      = card_rd_req && card_rd_ack && !launch;
        wr_fire      = card_wr_req && card_wr_ack && !launch;
        byte_step    = rd_fire || wr_fire;

        st_d          = st_q;
        eng_push      = 1'b0;
        eng_pop       = 1'b0;
        eng_push_data = {8'h00, card_rd_byte};

        if (done_clr) st_d.done = 1'b0;

        if (rd_fire) begin
            if (st_q.half) begin
                eng_push      = 1'b1;
                eng_push_data = {card_rd_byte, st_q.lo};
                st_d.half     = 1'b0;
            end else if (last_byte) begin
                eng_push = 1'b1;
            end else begin
                st_d.lo   = card_rd_byte;
                st_d.half = 1'b1;
            end
        end

        if (wr_fire) begin
            if (st_q.half) begin
                eng_pop   = 1'b1;
                st_d.half = 1'b0;
            end else if (last_byte) begin
                eng_pop = 1'b1;
            end else begin
                st_d.half = 1'b1;
            end
        end

        if (byte_step && last_byte && last_block) begin
            st_d.active = 1'b0;
            st_d.half   = 1'b0;
            st_d.done   = 1'b1;
        end

        if (launch) begin
            st_d.active = 1'b1;
            st_d.dir    = launch_dir;
            st_d.half   = 1'b0;
            st_d.lo     = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{active: 1'b0, dir: DIR_TO_CARD, half: 1'b0, lo: 8'h00, done: 1'b0};
        else        st_q <= st_d;
    end

    assign busy    = st_q.active;
    assign cur_dir = st_q.dir;
    assign done    = st_q.done;

endmodule

// File: rtl/blk_byte_xfer.sv
module blk_byte_xfer
    import bx_pkg::*;
#(
    parameter int AW       = 5,
    parameter int LEN_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic                cfg_sel,
    input  logic [LEN_BITS-1:0] cfg_wdata,
    input  logic [AW-1:0]       af_level,
    input  logic                launch,
    input  logic                launch_dir,
    input  logic                done_clr,
    input  logic                host_wr_en,
    input  logic [15:0]         host_wdata,
    input  logic                host_rd_en,
    output logic [15:0]         host_rdata,
    output logic [AW:0]         fifo_count,
    output logic                card_rd_req,
    input  logic                card_rd_ack,
    input  logic [7:0]          card_rd_byte,
    output logic                card_wr_req,
    input  logic                card_wr_ack,
    output logic [7:0]          card_wr_byte,
    output logic [LEN_BITS:0]   blen_left,
    output logic [LEN_BITS:0]   nblk_left,
    output logic                busy,
    output logic                done
);
    localparam int CW = LEN_BITS + 1;

    logic        byte_step, last_byte, last_block;
    logic        eng_push, eng_pop, host_push, host_pop;
    logic [15:0] eng_push_data, fifo_head;
    xfer_dir_e   cur_dir;

    bx_word_fifo #(.AW(AW), .DW(16)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (launch),
        .push      (eng_push || host_push),
        .push_data (eng_push ? eng_push_data : host_wdata),
        .pop       (eng_pop || host_pop),
        .head      (fifo_head),
        .count     (fifo_count)
    );

    bx_countdown #(.LEN_BITS(LEN_BITS)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr_en),
        .cfg_sel    (cfg_sel_e'(cfg_sel)),
        .cfg_data   (cfg_wdata),
        .step       (byte_step),
        .blen_left  (blen_left),
        .nblk_left  (nblk_left),
        .last_byte  (last_byte),
        .last_block (last_block)
    );

    bx_engine #(.AW(AW)) eng_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch        (launch),
        .launch_dir    (xfer_dir_e'(launch_dir)),
        .done_clr      (done_clr),
        .af_level      (af_level),
        .fifo_count    (fifo_count),
        .fifo_head     (fifo_head),
        .last_byte     (last_byte),
        .last_block    (last_block),
        .card_rd_req   (card_rd_req),
        .card_rd_ack   (card_rd_ack),
        .card_rd_byte  (card_rd_byte),
        .card_wr_req   (card_wr_req),
        .card_wr_ack   (card_wr_ack),
        .card_wr_byte  (card_wr_byte),
        .byte_step     (byte_step),
        .eng_push      (eng_push),
        .eng_push_data (eng_push_data),
        .eng_pop       (eng_pop),
        .busy          (busy),
        .cur_dir       (cur_dir),
        .done          (done)
    );

    // The host may only touch the FIFO side the engine is not using
    always_comb begin
        host_push = host_wr_en && !(busy && (cur_dir == DIR_FROM_CARD));
        host_pop  = host_rd_en && !(busy && (cur_dir == DIR_TO_CARD));
    end

    assign host_rdata = fifo_head;

endmodule

// File: rtl/blk_byte_xfer_chk.sv
module blk_byte_xfer_chk #(
    parameter int AW = 5,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          card_rd_req,
    input logic          card_wr_req,
    input logic          card_wr_ack,
    input logic          cfg_wr_en,
    input logic          launch,
    input logic          busy,
    input logic          done,
    input logic [AW:0]   fifo_count,
    input logic [CW-1:0] blen_left,
    input logic [CW-1:0] nblk_left
);
    localparam int DEPTH = 1 << AW;

    a_r11_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rd_req && card_wr_req));

    a_r8_no_byte_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
        card_wr_req |-> (fifo_count != '0));

    a_r9_counts_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (blen_left != '0) && (nblk_left != '0));

    a_r9_byte_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (card_wr_req && card_wr_ack && !cfg_wr_en && !launch && (blen_left > CW'(1)))
        |=> (blen_left == $past(blen_left) - CW'(1)));

    a_r4_launch_empties: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> ((fifo_count == '0) && busy));

    a_r10_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= (AW+1)'(DEPTH));

endmodule

bind blk_byte_xfer blk_byte_xfer_chk #(.AW(AW), .CW(CW)) chk_i (.*);

// File: tb/blk_byte_xfer_tb_top.sv
module blk_byte_xfer_tb_top;
    localparam int AW = 5;
    localparam int LB = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 0, cfg_sel = 0, launch = 0, launch_dir = 0, done_clr = 0;
    logic [LB-1:0] cfg_wdata = '0;
    logic [AW-1:0] af_level = 5'd31;
    logic host_wr_en = 0, host_rd_en = 0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [AW:0] fifo_count;
    logic card_rd_req, card_wr_req;
    logic card_rd_ack = 0, card_wr_ack = 0;
    logic [7:0] card_rd_byte = '0;
    logic [7:0] card_wr_byte;
    logic [LB:0] blen_left, nblk_left;
    logic busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    blk_byte_xfer #(.AW(AW), .LEN_BITS(LB)) dut_i (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg(logic sel, int val);
        cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = LB'(val);
        tick();
        cfg_wr_en = 0;
    endtask

    task automatic go(logic dir);
        launch = 1; launch_dir = dir;
        tick();
        launch = 0;
    endtask

    task automatic push_word(logic [15:0] w);
        host_wr_en = 1; host_wdata = w;
        tick();
        host_wr_en = 0;
    endtask

    task automatic pop_word(output logic [15:0] w);
        w = host_rdata;
        host_rd_en = 1;
        tick();
        host_rd_en = 0;
    endtask

    task automatic clear_done();
        done_clr = 1;
        tick();
        done_clr = 0;
        chk("R10 done cleared", int'(done), 0);
    endtask

    // Card to FIFO transfer, bytes numbered from 0; ack every gap cycles
    task automatic run_read(int blen, int nblk, int gap);
        int seq = 0;
        int b = 0;
        logic [15:0] w;
        cfg(0, blen - 1);
        cfg(1, nblk - 1);
        go(1);
        for (int cyc = 0; busy && cyc < 5000; cyc++) begin
            card_rd_ack  = card_rd_req && (cyc % gap == 0);
            card_rd_byte = 8'(seq);
            if (card_rd_ack) seq++;
            tick();
        end
        card_rd_ack = 0;
        chk("R11 bytes moved", seq, blen * nblk);
        chk("R10 done set", int'(done), 1);
        chk("R10 busy low", int'(busy), 0);
        chk("R10 block count reloaded", int'(nblk_left), nblk);
        chk("R9 byte count reloaded", int'(blen_left), blen);
        chk("R5 word count", int'(fifo_count), nblk * ((blen + 1) / 2));
        for (int k = 0; k < nblk; k++) begin
            for (int i = 0; i < blen; i += 2) begin
                int lo = b & 255;
                int hi = (i + 1 < blen) ? ((b + 1) & 255) : 0;
                b += (i + 1 < blen) ? 2 : 1;
                pop_word(w);
                chk("R5 packed word", int'(w), hi * 256 + lo);
            end
        end
        clear_done();
    endtask

    // FIFO to card transfer
    task automatic run_write(int blen, int nblk, int gap);
        int expb[64];
        int n_exp = 0;
        int n_got = 0;
        int nw = nblk * ((blen + 1) / 2);
        int k = 0;
        for (int blk = 0; blk < nblk; blk++) begin
            for (int i = 0; i < blen; i += 2) begin
                expb[n_exp++] = (8'h80 + 2 * k) & 255;
                if (i + 1 < blen) expb[n_exp++] = (8'h81 + 2 * k) & 255;
                k++;
            end
        end
        cfg(0, blen - 1);
        cfg(1, nblk - 1);
        go(0);
        for (int j = 0; j < nw; j++) push_word({8'(8'h81 + 2 * j), 8'(8'h80 + 2 * j)});
        for (int cyc = 0; busy && cyc < 5000; cyc++) begin
            card_wr_ack = card_wr_req && (cyc % gap == 0);
            if (card_wr_ack) begin
                chk("R6 byte order", int'(card_wr_byte), (n_got < n_exp) ? expb[n_got] : -1);
                n_got++;
            end
            tick();
        end
        card_wr_ack = 0;
        chk("R6 byte total", n_got, n_exp);
        chk("R6 fifo drained", int'(fifo_count), 0);
        chk("R10 done set", int'(done), 1);
        chk("R10 block count reloaded", int'(nblk_left), nblk);
        clear_done();
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] w;
        int n;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1 reset state
        chk("R1 blen_left", int'(blen_left), 1);
        chk("R1 nblk_left", int'(nblk_left), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fifo_count", int'(fifo_count), 0);
        chk("R1 requests", int'(card_rd_req) + int'(card_wr_req), 0);

        // R9 partial progress, then R3 and R2 reloads
        cfg(0, 2);
        cfg(1, 1);
        go(1);
        n = 0;
        while (n < 4) begin
            card_rd_ack = card_rd_req; card_rd_byte = 8'(n);
            if (card_rd_ack) n++;
            tick();
        end
        card_rd_ack = 0;
        chk("R9 byte countdown mid", int'(blen_left), 2);
        chk("R9 block countdown mid", int'(nblk_left), 1);
        chk("R5 words mid", int'(fifo_count), 2);
        cfg(1, 3);
        chk("R3 block count encoded", int'(nblk_left), 4);
        chk("R3 byte count reloaded", int'(blen_left), 3);
        cfg(0, 11'h405);
        chk("R2 block length encoded", int'(blen_left), 11'h406);
        go(0);
        chk("R4 launch empties fifo", int'(fifo_count), 0);
        chk("R4 busy", int'(busy), 1);

        // R8 and R12 in the FIFO-to-card direction
        cfg(0, 1);
        cfg(1, 0);
        go(0);
        tick();
        chk("R8 no request when empty", int'(card_wr_req), 0);
        push_word(16'h1234);
        chk("R12 push accepted", int'(fifo_count), 1);
        host_rd_en = 1; tick(); host_rd_en = 0;
        chk("R12 host pop ignored", int'(fifo_count), 1);
        chk("R8 request with data", int'(card_wr_req), 1);
        chk("R6 low byte first", int'(card_wr_byte), 8'h34);
        card_wr_ack = 1; tick();
        chk("R6 high byte second", int'(card_wr_byte), 8'h12);
        tick(); card_wr_ack = 0;
        chk("R10 single block end", int'(done), 1);
        clear_done();

        // R12 in the card-to-FIFO direction
        go(1);
        push_word(16'hBEEF);
        chk("R12 host push ignored", int'(fifo_count), 0);

        // R7 almost-full pause
        af_level = 5'd2;
        cfg(0, 15);
        cfg(1, 0);
        go(1);
        n = 0;
        for (int c = 0; c < 40; c++) begin
            card_rd_ack = card_rd_req; card_rd_byte = 8'(n);
            if (card_rd_ack) n++;
            tick();
        end
        card_rd_ack = 0;
        chk("R7 fifo stops above level", int'(fifo_count), 3);
        chk("R7 request low", int'(card_rd_req), 0);
        pop_word(w);
        chk("R7 first word", int'(w), 16'h0100);
        chk("R7 request resumes", int'(card_rd_req), 1);
        for (int c = 0; busy && c < 2000; c++) begin
            card_rd_ack = card_rd_req;
            card_rd_byte = 8'(n);
            if (card_rd_ack) n++;
            host_rd_en = (fifo_count != 0) && !card_rd_ack;
            tick();
        end
        card_rd_ack = 0; host_rd_en = 0;
        chk("R7 all bytes moved", n, 16);
        chk("R10 done after pause", int'(done), 1);
        while (fifo_count != 0) pop_word(w);
        clear_done();
        af_level = 5'd31;

        // Sweep block lengths and counts in both directions
        for (int bl = 1; bl <= 5; bl++)
            for (int nb = 1; nb <= 3; nb++) begin
                run_read(bl, nb, 1 + ((bl + nb) % 2));
                run_write(bl, nb, 1 + ((bl * nb) % 3));
            end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule